// File: doc/BRIEF.md
# Stereo Automatic Level Controller

This block keeps the peak level of two audio channels inside a window set by a low and a high threshold. It watches the signed 16-bit PCM samples of each channel, which are taken after the digital attenuator, and drives two gain controls per channel. The first is a coarse amplifier gain code. The second is a fine digital attenuation code. The analog gain stages and the sample multiplication sit elsewhere and only consume these codes.

Each channel holds the largest sample magnitude seen in its current measurement interval. The interval length is set by a rate code and counted in samples. When that peak goes above the high threshold, the block adds attenuation. It lowers the amplifier gain first and raises the digital attenuation only after the gain has reached zero. When the peak stays below the low threshold, the block removes attenuation in the reverse order. The amplifier gain is never raised above a ceiling that software sets for each channel.

Gain steps can move one half-decibel at a time (soft ramp) or in coarser jumps. They can optionally be held back until the channel's signal crosses zero. The two channels work independently, with one exception: channel B may only release when channel A is also below the low threshold.

Top module: `stereo_alc`

## Requirements
- R1: While reset is low, every gain code output is 0 after the clock edge.
- R2: When `alc_en` is low, after the next clock edge each amplifier gain code equals its clamped ceiling, each attenuation code is 0, and the measurement state is cleared. The clamped ceiling is min(ceiling input, 24).
- R3: On a valid sample, the interval peak is the largest magnitude over the interval, including that sample. The magnitude of -32768 is 32768. If this peak exceeds `max_thr` and the interval has reached 2^`atk_rate` samples, one attack step is decided and a new interval starts.
- R4: An attack step of S half-dB units first takes as much as it can from the amplifier gain, down to 0. The remainder is added to the attenuation code, which saturates at 96. A nonzero attenuation code therefore always comes with a gain code of 0.
- R5: A release step is decided when the interval peak is below `min_thr` and the interval has reached 2^`rel_rate` samples, and no attack is decided. It first takes as much as it can from the attenuation code, down to 0. The remainder raises the gain code, up to the clamped ceiling.
- R6: An interval whose peak lies between the thresholds changes no gain. The interval restarts after the longer of the two rate lengths.
- R7: Channel B may release only on a sample where channel A's interval peak is also below `min_thr`. Channel A does not depend on channel B.
- R8: The step size S is 1 when `ramp_en` is high and 4 when it is low.
- R9: With `zc_en` high, a decided step is held pending rather than applied. It is applied, at the size in force at that time, on a later valid sample whose sign bit differs from the channel's previous valid sample. A newer decision replaces a pending one. Lowering `zc_en` drops any pending step.
- R10: A gain code is never above the clamped ceiling sampled one cycle earlier. A ceiling that is lowered takes effect on the next edge.
- R11: Cycles with `smp_valid` low leave the gain codes unchanged, provided the ceiling does not drop below the current gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Both channel samples are valid this cycle |
| smp_a | input | 16 | Channel A sample, two's complement |
| smp_b | input | 16 | Channel B sample, two's complement |
| alc_en | input | 1 | Level control enable |
| ramp_en | input | 1 | Single half-dB steps when high |
| zc_en | input | 1 | Apply steps only at a sign change |
| max_thr | input | 16 | High peak threshold (magnitude) |
| min_thr | input | 16 | Low peak threshold (magnitude) |
| atk_rate | input | 3 | Attack interval code, 2^code samples |
| rel_rate | input | 3 | Release interval code, 2^code samples |
| ceil_a | input | 5 | Channel A gain ceiling, clamped to 24 |
| ceil_b | input | 5 | Channel B gain ceiling, clamped to 24 |
| pga_a | output | 5 | Channel A amplifier gain code, 0.5 dB units |
| att_a | output | 7 | Channel A digital attenuation code, 0.5 dB units |
| pga_b | output | 5 | Channel B amplifier gain code |
| att_b | output | 7 | Channel B digital attenuation code |

## Verification
All four gain codes are registered. A step decided on a valid sample appears right after the clock edge that takes that sample. A disable, a ceiling change or a reset shows up after one edge. A step held for zero-cross appears after the edge of the first valid sample whose sign differs. The bench drives each cycle's inputs between edges and advances its own reference model by exactly one edge. It compares all four codes 1 ns after every rising edge, so each result is checked in the cycle it is due and in no other.

// File: rtl/alc_pkg.sv
// Shared constants, gain type and step arithmetic for the stereo level controller.
// Assumes 16-bit samples, 0.5 dB code units, gain range 0..24, attenuation 0..96.
package alc_pkg;
    localparam int NCH      = 2;
    localparam int SMP_W    = 16;
    localparam int MAG_W    = SMP_W + 1;
    localparam int RATE_W   = 3;
    localparam int CNT_W    = 1 << RATE_W;      // holds 2^(2^RATE_W - 1)
    localparam int PGA_W    = 5;
    localparam int ATT_W    = 7;
    localparam int PGA_MAX  = 24;
    localparam int ATT_MAX  = 96;

    typedef struct packed {
        logic [PGA_W-1:0] pga;
        logic [ATT_W-1:0] att;
    } gain_t;

    // Attack: drain amplifier gain first, spill the rest into attenuation.
    function automatic gain_t attack_step(gain_t g, int s);
        gain_t r;
        int take;
        int a;
        take = (s < int'(g.pga)) ? s : int'(g.pga);
        a = int'(g.att) + (s - take);
        if (a > ATT_MAX) a = ATT_MAX;
        r.pga = PGA_W'(int'(g.pga) - take);
        r.att = ATT_W'(a);
        return r;
    endfunction

    // Release: drain attenuation first, spill the rest into gain up to the ceiling.
    function automatic gain_t release_step(gain_t g, int s, int ceil_c);
        gain_t r;
        int give;
        int p;
        give = (s < int'(g.att)) ? s : int'(g.att);
        p = int'(g.pga) + (s - give);
        if (p > ceil_c) p = ceil_c;
        r.att = ATT_W'(int'(g.att) - give);
        r.pga = PGA_W'(p);
        return r;
    endfunction
endpackage

// File: rtl/alc_detector.sv
// Per-channel peak detector: sample magnitude, interval peak hold, interval
// sample counter and sign tracking for zero-cross detection.
// Assumes the controller asserts restart only together with valid.
module alc_detector
    import alc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             valid,
    input  logic [SMP_W-1:0] smp,
    input  logic             restart,
    output logic [MAG_W-1:0] peak_now,
    output logic [CNT_W-1:0] cnt_next,
    output logic             crossing
);
    logic [MAG_W-1:0]        peak_q;
    logic [MAG_W-1:0]        mag;
    logic [CNT_W-1:0]        cnt_q;
    logic                    sign_q;
    logic signed [MAG_W-1:0] sx;

    // Magnitude, running peak including this sample, count and sign change.
    always_comb begin
        sx       = {smp[SMP_W-1], smp};
        mag      = sx[MAG_W-1] ? $unsigned(-sx) : $unsigned(sx);
        peak_now = (mag > peak_q) ? mag : peak_q;
        cnt_next = cnt_q + CNT_W'(1);
        crossing = smp[SMP_W-1] ^ sign_q;
    end

    // Interval state: cleared on reset or disable, restarted after a decision.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            peak_q <= '0;
            cnt_q  <= '0;
            sign_q <= 1'b0;
        end else if (valid) begin
            sign_q <= smp[SMP_W-1];
            if (restart) begin
                peak_q <= '0;
                cnt_q  <= '0;
            end else begin
                peak_q <= peak_now;
                cnt_q  <= cnt_next;
            end
        end
    end
endmodule

// File: rtl/alc_gain_ctrl.sv
// Per-channel gain controller: decides attack/release from the interval peak,
// applies steps in the fixed stage order, optionally deferring to zero-cross,
// and clamps the amplifier gain to the user ceiling.
// Assumes partner_under is tied high for a channel without a release dependency.
module alc_gain_ctrl
    import alc_pkg::*;
#(
    parameter int COARSE_STEPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alc_en,
    input  logic              valid,
    input  logic              ramp_en,
    input  logic              zc_en,
    input  logic [MAG_W-1:0]  peak_now,
    input  logic [CNT_W-1:0]  cnt_next,
    input  logic              crossing,
    input  logic [SMP_W-1:0]  max_thr,
    input  logic [SMP_W-1:0]  min_thr,
    input  logic [RATE_W-1:0] atk_rate,
    input  logic [RATE_W-1:0] rel_rate,
    input  logic [PGA_W-1:0]  ceil,
    input  logic              partner_under,
    output logic              under,
    output logic              restart,
    output logic [PGA_W-1:0]  pga,
    output logic [ATT_W-1:0]  att
);
    logic [CNT_W-1:0] atk_len;
    logic [CNT_W-1:0] rel_len;
    logic [CNT_W-1:0] long_len;
    logic             over;
    logic             do_atk;
    logic             do_rel;
    logic [PGA_W-1:0] ceil_c;
    int               step;
    gain_t            cur;
    gain_t            nxt;
    logic             pend_v_q;
    logic             pend_d_q;
    logic             pend_v_n;
    logic             pend_d_n;
    logic [PGA_W-1:0] pga_q;
    logic [ATT_W-1:0] att_q;

    // Interval lengths, threshold compares and the step decision.
    always_comb begin
        atk_len  = CNT_W'(1) << atk_rate;
        rel_len  = CNT_W'(1) << rel_rate;
        long_len = (atk_len > rel_len) ? atk_len : rel_len;
        over     = peak_now > {1'b0, max_thr};
        under    = peak_now < {1'b0, min_thr};
        do_atk   = valid && over && (cnt_next >= atk_len);
        do_rel   = valid && !do_atk && under && partner_under && (cnt_next >= rel_len);
        restart  = do_atk || do_rel || (valid && (cnt_next >= long_len));
    end

    // Next gain: immediate or zero-cross deferred step, then ceiling clamp.
    always_comb begin
        step     = ramp_en ? 1 : COARSE_STEPS;
        ceil_c   = (int'(ceil) > PGA_MAX) ? PGA_W'(PGA_MAX) : ceil;
        cur.pga  = pga_q;
        cur.att  = att_q;
        nxt      = cur;
        pend_v_n = pend_v_q;
        pend_d_n = pend_d_q;
        if (!zc_en) begin
            pend_v_n = 1'b0;
            if (do_atk)      nxt = attack_step(cur, step);
            else if (do_rel) nxt = release_step(cur, step, int'(ceil_c));
        end else if (do_atk || do_rel) begin
            pend_v_n = 1'b1;
            pend_d_n = do_atk;
        end else if (valid && pend_v_q && crossing) begin
            pend_v_n = 1'b0;
            nxt = pend_d_q ? attack_step(cur, step) : release_step(cur, step, int'(ceil_c));
        end
        if (nxt.pga > ceil_c) nxt.pga = ceil_c;
    end

    // Gain and pending-step registers; disable snaps to ceiling with no attenuation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pga_q    <= '0;
            att_q    <= '0;
            pend_v_q <= 1'b0;
            pend_d_q <= 1'b0;
        end else if (!alc_en) begin
            pga_q    <= ceil_c;
            att_q    <= '0;
            pend_v_q <= 1'b0;
            pend_d_q <= 1'b0;
        end else begin
            pga_q    <= nxt.pga;
            att_q    <= nxt.att;
            pend_v_q <= pend_v_n;
            pend_d_q <= pend_d_n;
        end
    end

    assign pga = pga_q;
    assign att = att_q;
endmodule

// File: rtl/stereo_alc.sv
// Stereo automatic level controller top: one detector and one gain controller
// per channel; channel B release is gated by channel A being below MIN.
// Assumes both channel samples share one valid strobe.
module stereo_alc
    import alc_pkg::*;
#(
    parameter int COARSE_STEPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_a,
    input  logic [SMP_W-1:0]  smp_b,
    input  logic              alc_en,
    input  logic              ramp_en,
    input  logic              zc_en,
    input  logic [SMP_W-1:0]  max_thr,
    input  logic [SMP_W-1:0]  min_thr,
    input  logic [RATE_W-1:0] atk_rate,
    input  logic [RATE_W-1:0] rel_rate,
    input  logic [PGA_W-1:0]  ceil_a,
    input  logic [PGA_W-1:0]  ceil_b,
    output logic [PGA_W-1:0]  pga_a,
    output logic [ATT_W-1:0]  att_a,
    output logic [PGA_W-1:0]  pga_b,
    output logic [ATT_W-1:0]  att_b
);
    logic [SMP_W-1:0] smp_w     [NCH];
    logic [PGA_W-1:0] ceil_w    [NCH];
    logic [PGA_W-1:0] pga_w     [NCH];
    logic [ATT_W-1:0] att_w     [NCH];
    logic [MAG_W-1:0] peak_w    [NCH];
    logic [CNT_W-1:0] cnt_w     [NCH];
    logic             cross_w   [NCH];
    logic             under_w   [NCH];
    logic             restart_w [NCH];

    assign smp_w[0]  = smp_a;
    assign smp_w[1]  = smp_b;
    assign ceil_w[0] = ceil_a;
    assign ceil_w[1] = ceil_b;
    assign pga_a     = pga_w[0];
    assign att_a     = att_w[0];
    assign pga_b     = pga_w[1];
    assign att_b     = att_w[1];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        alc_detector u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (!alc_en),
            .valid    (smp_valid),
            .smp      (smp_w[ch]),
            .restart  (restart_w[ch]),
            .peak_now (peak_w[ch]),
            .cnt_next (cnt_w[ch]),
            .crossing (cross_w[ch])
        );

        alc_gain_ctrl #(.COARSE_STEPS(COARSE_STEPS)) u_ctl (
            .clk           (clk),
            .rst_n         (rst_n),
            .alc_en        (alc_en),
            .valid         (smp_valid),
            .ramp_en       (ramp_en),
            .zc_en         (zc_en),
            .peak_now      (peak_w[ch]),
            .cnt_next      (cnt_w[ch]),
            .crossing      (cross_w[ch]),
            .max_thr       (max_thr),
            .min_thr       (min_thr),
            .atk_rate      (atk_rate),
            .rel_rate      (rel_rate),
            .ceil          (ceil_w[ch]),
            .partner_under ((ch == 0) ? 1'b1 : under_w[0]),
            .under         (under_w[ch]),
            .restart       (restart_w[ch]),
            .pga           (pga_w[ch]),
            .att           (att_w[ch])
        );
    end
endmodule

// File: rtl/stereo_alc_checker.sv
// Assertion checker for stereo_alc, bound into every instance of the top.
// Assumes the port widths of the default configuration.
module stereo_alc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       alc_en,
    input logic       smp_valid,
    input logic       zc_en,
    input logic [4:0] ceil_a,
    input logic [4:0] ceil_b,
    input logic [4:0] pga_a,
    input logic [6:0] att_a,
    input logic [4:0] pga_b,
    input logic [6:0] att_b,
    input logic       under_a
);
    function automatic logic [4:0] clampc(logic [4:0] c);
        return (c > 5'd24) ? 5'd24 : c;
    endfunction

    a_r4_order_a: assert property (@(posedge clk) disable iff (!rst_n)
        (att_a != 7'd0) |-> (pga_a == 5'd0));
    a_r4_order_b: assert property (@(posedge clk) disable iff (!rst_n)
        (att_b != 7'd0) |-> (pga_b == 5'd0));
    a_r4_att_limit: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> (att_a <= 7'd96) && (att_b <= 7'd96));
    a_r10_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pga_a <= clampc($past(ceil_a))) && (pga_b <= clampc($past(ceil_b))));
    a_r2_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !alc_en |=> (pga_a == clampc($past(ceil_a))) && (att_a == 7'd0) && (att_b == 7'd0));
    a_r11_idle_a: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && !smp_valid && pga_a <= clampc(ceil_a)) |=> $stable(pga_a) && $stable(att_a));
    a_r7_b_waits_for_a: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && smp_valid && !zc_en && !under_a) |=>
            !(att_b < $past(att_b)) && !(pga_b > $past(pga_b)));
endmodule

bind stereo_alc stereo_alc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alc_en    (alc_en),
    .smp_valid (smp_valid),
    .zc_en     (zc_en),
    .ceil_a    (ceil_a),
    .ceil_b    (ceil_b),
    .pga_a     (pga_a),
    .att_a     (att_a),
    .pga_b     (pga_b),
    .att_b     (att_b),
    .under_a   (under_w[0])
);

// File: tb/stereo_alc_tb_top.sv
// Self-checking bench: seeded random samples and configurations plus directed
// corners, compared each cycle against a bench reference model.
module stereo_alc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_a = '0;
    logic [15:0] smp_b = '0;
    logic        alc_en = 1'b0;
    logic        ramp_en = 1'b1;
    logic        zc_en = 1'b0;
    logic [15:0] max_thr = 16'd8000;
    logic [15:0] min_thr = 16'd2000;
    logic [2:0]  atk_rate = 3'd0;
    logic [2:0]  rel_rate = 3'd0;
    logic [4:0]  ceil_a = 5'd20;
    logic [4:0]  ceil_b = 5'd30;
    logic [4:0]  pga_a;
    logic [6:0]  att_a;
    logic [4:0]  pga_b;
    logic [6:0]  att_b;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    int m_pga[2], m_att[2], m_peak[2], m_cnt[2], m_sign[2], m_pv[2], m_pd[2];

    always #2 clk = ~clk;

    stereo_alc dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
        .alc_en(alc_en), .ramp_en(ramp_en), .zc_en(zc_en), .max_thr(max_thr),
        .min_thr(min_thr), .atk_rate(atk_rate), .rel_rate(rel_rate),
        .ceil_a(ceil_a), .ceil_b(ceil_b), .pga_a(pga_a), .att_a(att_a),
        .pga_b(pga_b), .att_b(att_b)
    );

    function automatic int clampc(int c);
        return (c > 24) ? 24 : c;
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    // Reference: state after the coming edge, from the current inputs.
    task automatic model_step();
        int pk[2], cn[2], und[2], crs[2], sg[2];
        if (!rst_n) begin
            for (int ch = 0; ch < 2; ch++) begin
                m_pga[ch] = 0; m_att[ch] = 0; m_peak[ch] = 0; m_cnt[ch] = 0;
                m_sign[ch] = 0; m_pv[ch] = 0; m_pd[ch] = 0;
            end
            return;
        end
        if (!alc_en) begin
            for (int ch = 0; ch < 2; ch++) begin
                m_pga[ch] = clampc(ch == 0 ? int'(ceil_a) : int'(ceil_b));
                m_att[ch] = 0; m_peak[ch] = 0; m_cnt[ch] = 0;
                m_sign[ch] = 0; m_pv[ch] = 0; m_pd[ch] = 0;
            end
            return;
        end
        for (int ch = 0; ch < 2; ch++) begin
            logic [15:0] x;
            int mag;
            x = (ch == 0) ? smp_a : smp_b;
            mag = x[15] ? 65536 - int'(x) : int'(x);
            pk[ch] = (mag > m_peak[ch]) ? mag : m_peak[ch];
            cn[ch] = m_cnt[ch] + 1;
            und[ch] = (pk[ch] < int'(min_thr)) ? 1 : 0;
            sg[ch] = int'(x[15]);
            crs[ch] = (sg[ch] != m_sign[ch]) ? 1 : 0;
        end
        for (int ch = 0; ch < 2; ch++) begin
            int al, rl, ll, st, cc, np, na, mv;
            bit datk, drel;
            al = 1 << atk_rate; rl = 1 << rel_rate; ll = (al > rl) ? al : rl;
            datk = smp_valid && pk[ch] > int'(max_thr) && cn[ch] >= al;
            drel = smp_valid && !datk && und[ch] == 1 && (ch == 0 || und[0] == 1) && cn[ch] >= rl;
            st = ramp_en ? 1 : 4;
            cc = clampc(ch == 0 ? int'(ceil_a) : int'(ceil_b));
            np = m_pga[ch]; na = m_att[ch];
            mv = 0;  // 1 attack, 2 release
            if (!zc_en) begin
                m_pv[ch] = 0;
                mv = datk ? 1 : (drel ? 2 : 0);
            end else if (datk || drel) begin
                m_pv[ch] = 1; m_pd[ch] = datk ? 1 : 0;
            end else if (smp_valid && m_pv[ch] == 1 && crs[ch] == 1) begin
                m_pv[ch] = 0;
                mv = (m_pd[ch] == 1) ? 1 : 2;
            end
            if (mv == 1) begin
                int t;
                t = imin(st, np); np -= t; na = imin(na + st - t, 96);
            end else if (mv == 2) begin
                int g;
                g = imin(st, na); na -= g; np = imin(np + st - g, cc);
            end
            if (np > cc) np = cc;
            m_pga[ch] = np; m_att[ch] = na;
            if (smp_valid) begin
                m_sign[ch] = sg[ch];
                if (datk || drel || cn[ch] >= ll) begin
                    m_peak[ch] = 0; m_cnt[ch] = 0;
                end else begin
                    m_peak[ch] = pk[ch]; m_cnt[ch] = cn[ch];
                end
            end
        end
    endtask

    task automatic check(input string tag);
        vectors++;
        if (int'(pga_a) != m_pga[0] || int'(att_a) != m_att[0] ||
            int'(pga_b) != m_pga[1] || int'(att_b) != m_att[1]) begin
            fails++;
            $display("FAIL %s: got pga_a=%0d att_a=%0d pga_b=%0d att_b=%0d, expected %0d %0d %0d %0d",
                     tag, pga_a, att_a, pga_b, att_b, m_pga[0], m_att[0], m_pga[1], m_att[1]);
        end
    endtask

    task automatic cyc(input string tag, input bit v, input int a, input int b);
        smp_valid = v; smp_a = 16'(a); smp_b = 16'(b);
        model_step();
        @(posedge clk); #1;
        check(tag);
    endtask

    function automatic int gen(int amp);
        int v;
        v = int'($urandom_range(amp, 0));
        if ($urandom_range(1, 0) == 1) v = -v;
        return v;
    endfunction

    // n cycles of random samples of amplitude up to ampa/ampb; vpct percent valid.
    task automatic run(input string tag, input int n, input int ampa, input int ampb, input int vpct);
        for (int i = 0; i < n; i++)
            cyc(tag, $urandom_range(99, 0) < vpct, gen(ampa), gen(ampb));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset clears the gain codes
        for (int i = 0; i < 4; i++) cyc("R1 reset", 1'b0, 0, 0);
        rst_n = 1'b1;
        // R2 / R10: disabled outputs track the clamped ceiling (30 clamps to 24)
        for (int i = 0; i < 6; i++) cyc("R2 R10 disabled ceiling", 1'b1, 30000, 30000);
        alc_en = 1'b1;
        // R3: full-scale negative sample, magnitude 32768 exceeds 32767
        max_thr = 16'd32767;
        cyc("R3 full-scale negative", 1'b1, 16'h8000, 0);
        cyc("R3 full-scale negative", 1'b1, 32767, 32767);
        max_thr = 16'd8000;
        // R4: loud input drains gain, then saturates attenuation at 96
        run("R4 attack order", 400, 30000, 30000, 100);
        // R5: quiet input removes attenuation then restores gain to ceiling
        run("R5 release order", 500, 500, 500, 100);
        // R7: B attenuated, then A mid-band must block B's release
        run("R3 attack", 60, 30000, 30000, 100);
        for (int i = 0; i < 200; i++) cyc("R7 B waits for A", 1'b1, (i % 2) ? 5000 : -5000, gen(500));
        run("R7 A free", 200, 500, 20000, 100);
        // R6: mid-band peaks change nothing
        atk_rate = 3'd7; rel_rate = 3'd7;
        for (int i = 0; i < 300; i++) cyc("R6 mid band", 1'b1, (i % 3) ? gen(5000) : 5000, -4000);
        // R8: coarse steps
        ramp_en = 1'b0; atk_rate = 3'd1; rel_rate = 3'd2;
        run("R8 coarse attack", 120, 30000, 30000, 100);
        run("R8 coarse release", 200, 300, 300, 100);
        // R9: zero-cross deferral, including long same-sign stretches
        ramp_en = 1'b1; zc_en = 1'b1;
        for (int i = 0; i < 300; i++) cyc("R9 zero cross", 1'b1, ((i / 17) % 2) ? 30000 : -29000, ((i / 5) % 2) ? 200 : -200);
        run("R9 zero cross random", 400, 20000, 1500, 100);
        zc_en = 1'b0;
        // R11: idle cycles between valid samples
        run("R11 sparse valid", 800, 25000, 25000, 30);
        run("R11 sparse valid quiet", 800, 800, 800, 30);
        // R10: ceiling moves while active
        for (int k = 0; k < 20; k++) begin
            ceil_a = 5'($urandom_range(31, 0)); ceil_b = 5'($urandom_range(31, 0));
            run("R10 ceiling change", 40, (k % 2) ? 400 : 20000, 400, 100);
        end
        // R2: enable toggling mid-operation
        for (int k = 0; k < 20; k++) begin
            alc_en = (k % 3) != 0;
            run("R2 enable toggle", 30, 30000, 1000, 90);
        end
        alc_en = 1'b1;
        // R3: fully random configurations
        for (int k = 0; k < 60; k++) begin
            ramp_en = 1'($urandom_range(1, 0)); zc_en = 1'($urandom_range(1, 0));
            atk_rate = 3'($urandom_range(7, 0)); rel_rate = 3'($urandom_range(7, 0));
            max_thr = 16'($urandom_range(30000, 4000)); min_thr = 16'($urandom_range(3000, 0));
            ceil_a = 5'($urandom_range(31, 0)); ceil_b = 5'($urandom_range(31, 0));
            run("R3 random", 200, int'($urandom_range(32767, 0)), int'($urandom_range(32767, 0)), 70);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule